// File: doc/BRIEF.md
# Two-Wire Timekeeping Register Slave

This block is a two-wire serial slave (I2C-style) that gives a bus master access to eight byte-wide timekeeping registers. Its addresses are 0 to 7: seconds, minutes, century/hours, day, date, month, year and calibration. The block oversamples SCL and SDA with the system clock and detects START, repeated START and STOP from the sampled lines. It matches a fixed 7-bit device address and drives SDA only as an open-drain pull-down. The register storage lives outside the block. It is reached through a combinational read port and a one-cycle write strobe, both addressed by the block's internal word pointer.

A write transaction sends the device address with R/W=0 and then one pointer byte. Any further bytes are written at the pointer, which advances after each byte. A random read first writes the pointer, then issues a repeated START with R/W=1. A current-address read skips the pointer write and continues from wherever the pointer was left. A power-fail input aborts any transaction, releases SDA and returns the pointer to 0.

Top module: `twr_regslave`

## Requirements
- R1: After reset, sda_oe and reg_wr are 0 and the word pointer is 0, so a current-address read that follows reset returns register 0.
- R2: The device address byte is sent MSB first. Its upper seven bits must equal 1101000, and bit 0 is R/W (0 = write, 1 = read). On a match the slave holds SDA low through the entire high period of the ninth clock.
- R3: The slave changes sda_oe only while SCL is low, except when it releases SDA in response to power-fail.
- R4: When the address does not match, the slave does not acknowledge and does not write. It then ignores the bus until the next START.
- R5: In a write transaction the first byte after the address loads the pointer from its low three bits and is acknowledged. Each later byte is written at the pointer with a single one-cycle reg_wr pulse and is acknowledged.
- R6: The pointer advances by one only on the acknowledge clock of a written data byte or of a master-acknowledged read byte. It wraps from 7 to 0.
- R7: After the read address is acknowledged, the slave transmits the byte at the pointer MSB first. Each time the master acknowledges, the slave transmits the byte at the next address.
- R8: When the master does not acknowledge a read byte, the slave leaves SDA released and goes idle, and the pointer does not advance.
- R9: A read that is not preceded by a pointer write starts at the last pointer value, and that value survives STOP.
- R10: While pwr_fail is high, the slave releases SDA, clears the pointer to 0, writes nothing and acknowledges nothing.
- R11: A STOP returns the slave to idle, and bytes clocked after a STOP without a new START are neither acknowledged nor written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line from the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| pwr_fail | input | 1 | Supply out of tolerance: abort and clear the pointer |
| reg_addr | output | 3 | Register index, equal to the word pointer |
| reg_wr | output | 1 | One-cycle write strobe for reg_wdata at reg_addr |
| reg_wdata | output | 8 | Byte to be written |
| reg_rdata | input | 8 | Combinational read data of the register at reg_addr |

## Verification
The assertions check several properties on every cycle. They check that the pull-down never changes while the sampled SCL is high, that power-fail leaves SDA released with the pointer at 0, that each write strobe lasts a single cycle, and that the idle state never drives SDA. They also check that the pointer moves only when it is loaded, stepped or cleared. Other behaviour can only be shown by the bench's scenarios, because it depends on transaction history. That includes which register a byte lands in, the wrap from 7 to 0, a current-address read resuming from the pointer after STOP, the absence of a pointer step on a master NACK, and a mismatched or STOP-terminated transfer being ignored.

// File: rtl/twr_pkg.sv
package twr_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_WPTR,
        S_WDATA,
        S_ACK,
        S_RDATA,
        S_RACK
    } twr_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } twr_line_t;

    function automatic logic id_match(input logic [7:0] hdr, input logic [6:0] id);
        return hdr[7:1] == id;
    endfunction

endpackage

// File: rtl/twr_linemon.sv
module twr_linemon
    import twr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      scl_i,
    input  logic      sda_i,
    output twr_line_t line
);
    logic [SYNC_STAGES:0] scl_p;
    logic [SYNC_STAGES:0] sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= '1;
            sda_p <= '1;
        end else begin
            scl_p <= {scl_p[SYNC_STAGES-1:0], scl_i};
            sda_p <= {sda_p[SYNC_STAGES-1:0], sda_i};
        end
    end

    logic scl_s, scl_q, sda_s, sda_q;
    assign scl_s = scl_p[SYNC_STAGES-1];
    assign scl_q = scl_p[SYNC_STAGES];
    assign sda_s = sda_p[SYNC_STAGES-1];
    assign sda_q = sda_p[SYNC_STAGES];

    always_comb begin
        line.scl   = scl_s;
        line.sda   = sda_s;
        line.rise  = scl_s & ~scl_q;
        line.fall  = ~scl_s & scl_q;
        line.start = scl_s & scl_q & sda_q & ~sda_s;
        line.stop  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/twr_ptr.sv
module twr_ptr #(
    parameter int NREG = 8,
    parameter int AW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc,
    output logic [AW-1:0] ptr
);
    localparam logic [AW-1:0] LAST = AW'(NREG - 1);

    always_ff @(posedge clk) begin
        if (rst || clr)
            ptr <= '0;
        else if (load)
            ptr <= load_val;
        else if (inc)
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!clr && !load && !inc) |=> $stable(ptr)); // R6
endmodule

// File: rtl/twr_regslave.sv
module twr_regslave
    import twr_pkg::*;
#(
    parameter logic [6:0] DEV_ID      = 7'b1101000,
    parameter int         NREG        = 8,
    parameter int         DW          = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    scl_i,
    input  logic                    sda_i,
    output logic                    sda_oe,
    input  logic                    pwr_fail,
    output logic [$clog2(NREG)-1:0] reg_addr,
    output logic                    reg_wr,
    output logic [DW-1:0]           reg_wdata,
    input  logic [DW-1:0]           reg_rdata
);
    localparam int AW = $clog2(NREG);
    localparam int CW = $clog2(DW + 1);
    localparam logic [CW-1:0] FULL = CW'(DW);

    twr_line_t  ev;
    twr_state_e state, after_ack;
    logic [CW-1:0] cnt;
    logic [DW-1:0] rxsh, txsh;
    logic ack_inc, mack;
    logic ptr_load, ptr_inc, busq;
    logic [AW-1:0] ptr;

    twr_linemon #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .line(ev)
    );

    // events that a START, STOP or power-fail overrides
    assign busq = !pwr_fail && !ev.start && !ev.stop;

    always_comb begin
        ptr_load = busq && state == S_WPTR && ev.fall && cnt == FULL;
        ptr_inc  = busq && ev.rise &&
                   ((state == S_ACK && ack_inc) || (state == S_RACK && !ev.sda));
    end

    twr_ptr #(.NREG(NREG), .AW(AW)) u_ptr (
        .clk(clk), .rst(rst), .clr(pwr_fail), .load(ptr_load),
        .load_val(rxsh[AW-1:0]), .inc(ptr_inc), .ptr(ptr)
    );

    assign reg_addr = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            after_ack <= S_IDLE;
            cnt       <= '0;
            rxsh      <= '0;
            txsh      <= '0;
            sda_oe    <= 1'b0;
            reg_wr    <= 1'b0;
            reg_wdata <= '0;
            ack_inc   <= 1'b0;
            mack      <= 1'b0;
        end else begin
            reg_wr <= 1'b0;
            if (pwr_fail) begin
                state  <= S_IDLE;
                sda_oe <= 1'b0;
            end else if (ev.start) begin
                state  <= S_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                state  <= S_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    S_ADDR, S_WPTR, S_WDATA: begin
                        if (ev.rise && cnt != FULL) begin
                            rxsh <= {rxsh[DW-2:0], ev.sda};
                            cnt  <= cnt + 1'b1;
                        end else if (ev.fall && cnt == FULL) begin
                            ack_inc <= 1'b0;
                            state   <= S_ACK;
                            sda_oe  <= 1'b1;
                            if (state == S_ADDR) begin
                                if (id_match(rxsh, DEV_ID))
                                    after_ack <= rxsh[0] ? S_RDATA : S_WPTR;
                                else begin
                                    state  <= S_IDLE;
                                    sda_oe <= 1'b0;
                                end
                            end else begin
                                after_ack <= S_WDATA;
                                if (state == S_WDATA) begin
                                    ack_inc   <= 1'b1;
                                    reg_wr    <= 1'b1;
                                    reg_wdata <= rxsh;
                                end
                            end
                        end
                    end
                    S_ACK: begin
                        if (ev.fall) begin
                            cnt    <= '0;
                            state  <= after_ack;
                            sda_oe <= 1'b0;
                            if (after_ack == S_RDATA) begin
                                txsh   <= reg_rdata;
                                sda_oe <= ~reg_rdata[DW-1];
                            end
                        end
                    end
                    S_RDATA: begin
                        if (ev.rise)
                            cnt <= cnt + 1'b1;
                        else if (ev.fall && cnt == FULL) begin
                            sda_oe <= 1'b0;
                            state  <= S_RACK;
                        end else if (ev.fall && cnt != '0) begin
                            txsh   <= txsh << 1;
                            sda_oe <= ~txsh[DW-2];
                        end
                    end
                    S_RACK: begin
                        if (ev.rise)
                            mack <= !ev.sda;
                        else if (ev.fall) begin
                            if (mack) begin
                                txsh   <= reg_rdata;
                                sda_oe <= ~reg_rdata[DW-1];
                                cnt    <= '0;
                                state  <= S_RDATA;
                            end else
                                state  <= S_IDLE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_OE_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (ev.scl && !pwr_fail && !ev.start && !ev.stop) |=> $stable(sda_oe)); // R3
    AST_PF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        pwr_fail |=> (!sda_oe && reg_addr == '0 && !reg_wr)); // R10
    AST_WR_PULSE: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> !reg_wr); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE) |-> !sda_oe); // R4
endmodule

// File: tb/test_twr_regslave.sv
`timescale 1ns/1ps
module test_twr_regslave;
    localparam int Q = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1, pf = 1'b0;
    logic sda_oe, reg_wr;
    logic [2:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic [7:0] mem [8];
    logic sda_line;
    int checks = 0, errors = 0, wr_count = 0, r3_viol = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    assign sda_line  = sda_m & ~sda_oe;
    assign reg_rdata = mem[reg_addr];

    twr_regslave i_twr_regslave (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .pwr_fail(pf), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic logic [7:0] init_val(int i);
        return 8'(i * 17 + 3);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 8; i++) mem[i] <= init_val(i);
        end else if (reg_wr) begin
            mem[reg_addr] <= reg_wdata;
            wr_count <= wr_count + 1;
        end
    end

    // R3 monitor: pull-down must not change while SCL is high
    logic prev_scl = 1'b1, prev_oe = 1'b0;
    always @(posedge clk) begin
        if (!rst && !pf && scl_m && prev_scl && sda_oe != prev_oe) r3_viol <= r3_viol + 1;
        prev_scl <= scl_m;
        prev_oe  <= sda_oe;
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    endtask

    // returns 1 only if the line is low at both ends of the high period
    task automatic get_bit(output logic b, output logic low_all);
        logic s0, s1;
        sda_m = 1'b1; wq(); scl_m = 1'b1; @(negedge clk); s0 = sda_line;
        wq(); s1 = sda_line; scl_m = 1'b0; wq();
        b = s1; low_all = !s0 && !s1;
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic b, l;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b, l);
        ack = l;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        logic b, l;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b, l);
            d[i] = b;
        end
        put_bit(!give_ack);
    endtask

    task automatic t_reset();
        logic ack; logic [7:0] d;
        chk(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);
        chk(reg_wr == 1'b0, "R1 reg_wr after reset", reg_wr, 0);
        bus_start(); send_byte(8'hD1, ack);
        chk(ack, "R2 read address ack", ack, 1);
        recv_byte(1'b0, d); bus_stop();
        chk(d == init_val(0), "R1 R9 first current read", d, init_val(0));
    endtask

    task automatic t_write();
        logic a0, a1, a2, a3; int wc;
        wc = wr_count;
        bus_start(); send_byte(8'hD0, a0);
        chk(a0, "R2 write address ack", a0, 1);
        send_byte(8'h03, a1); send_byte(8'hA5, a2); send_byte(8'h5A, a3); bus_stop();
        chk(a1 && a2 && a3, "R5 data bytes acked", {a1, a2, a3}, 7);
        chk(mem[3] == 8'hA5, "R5 byte at pointer", mem[3], 8'hA5);
        chk(mem[4] == 8'h5A, "R6 pointer stepped", mem[4], 8'h5A);
        chk(wr_count - wc == 2, "R5 one strobe per byte", wr_count - wc, 2);
    endtask

    task automatic t_wrap_write();
        logic a;
        bus_start(); send_byte(8'hD0, a); send_byte(8'h06, a);
        send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h33, a); bus_stop();
        chk(mem[6] == 8'h11 && mem[7] == 8'h22, "R6 write before wrap", {mem[6], mem[7]}, 16'h1122);
        chk(mem[0] == 8'h33, "R6 write wraps to 0", mem[0], 8'h33);
    endtask

    task automatic t_random_read();
        logic a; logic [7:0] d0, d1, d2;
        bus_start(); send_byte(8'hD0, a); send_byte(8'h03, a);
        bus_start(); send_byte(8'hD1, a);
        chk(a, "R7 repeated start read ack", a, 1);
        recv_byte(1'b1, d0); recv_byte(1'b0, d1);
        chk(d0 == 8'hA5, "R7 byte at pointer", d0, 8'hA5);
        chk(d1 == 8'h5A, "R7 next byte after ack", d1, 8'h5A);
        chk(sda_oe == 1'b0, "R8 released after nack", sda_oe, 0);
        bus_stop();
        bus_start(); send_byte(8'hD1, a); recv_byte(1'b0, d2); bus_stop();
        chk(d2 == 8'h5A, "R8 R9 no step on nack, resume after stop", d2, 8'h5A);
        bus_start(); send_byte(8'hD0, a); send_byte(8'h07, a);
        bus_start(); send_byte(8'hD1, a); recv_byte(1'b1, d0); recv_byte(1'b0, d1); bus_stop();
        chk(d0 == 8'h22 && d1 == 8'h33, "R6 read wraps 7 to 0", {d0, d1}, 16'h2233);
    endtask

    task automatic t_mismatch();
        logic a, b; int wc;
        wc = wr_count;
        bus_start(); send_byte(8'hA0, a);
        chk(!a, "R4 foreign address not acked", a, 0);
        send_byte(8'h02, b); send_byte(8'hEE, b);
        chk(!b, "R4 later bytes ignored", b, 0);
        bus_stop();
        bus_start(); send_byte(8'hD0, a); send_byte(8'h01, a); bus_stop();
        send_byte(8'h99, b);
        chk(!b, "R11 byte after stop not acked", b, 0);
        bus_stop();
        chk(wr_count == wc && mem[1] == init_val(1), "R4 R11 nothing written", mem[1], init_val(1));
    endtask

    task automatic t_powerfail();
        logic a; logic [7:0] d; int wc;
        bus_start(); send_byte(8'hD0, a); send_byte(8'h05, a);
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
        pf = 1'b1; repeat (3) @(negedge clk);
        chk(sda_oe == 1'b0, "R10 released on power-fail", sda_oe, 0);
        bus_stop();
        wc = wr_count;
        bus_start(); send_byte(8'hD0, a);
        chk(!a, "R10 no ack while power-fail", a, 0);
        send_byte(8'h02, a); send_byte(8'h44, a); bus_stop();
        chk(wr_count == wc, "R10 no write while power-fail", wr_count - wc, 0);
        pf = 1'b0; wq();
        bus_start(); send_byte(8'hD1, a); recv_byte(1'b0, d); bus_stop();
        chk(d == 8'h33, "R10 pointer cleared to 0", d, 8'h33);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        t_reset();
        t_write();
        t_wrap_write();
        t_random_read();
        t_mismatch();
        t_powerfail();
        chk(r3_viol == 0, "R3 sda_oe moved while SCL high", r3_viol, 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule